// File: doc/BRIEF.md
# Register Rename Map

This block keeps, for every architectural register, a record of whether the newest value of that register is still being computed by an instruction in the reorder buffer. When it is, the block also records the reorder-buffer tag of the instruction that will produce the value. The decode stage looks up both source registers of the instruction it is decoding in the same cycle that it reads the register file. For each source, a set pending flag tells decode to wait on the returned tag. A clear pending flag tells decode to use the register-file value.

When decode allocates a reorder-buffer slot to an instruction that writes a register, it writes that slot's tag into the destination entry and marks the entry pending. When an instruction commits, the commit stage offers its destination and tag. The entry is released only if it still names that same tag. If a younger writer of the same register is still in flight, the entry keeps that writer's mapping. Register 0 is hard-wired and is never renamed.

Top module: `rename_map`

## Requirements
- R1: After a synchronous active-low reset, every entry reads as not pending on both lookup ports.
- R2: A lookup of a pending entry returns pend=1 and that entry's stored tag. A lookup of a non-pending entry returns pend=0 and tag=0. Both results are combinational on the index in the same cycle.
- R3: The two lookup ports are independent and can read different registers in the same cycle.
- R4: A decode write (wr_en=1) to register d≠0 with tag t makes d read pend=1, tag=t from the following cycle onward.
- R5: A commit (cm_en=1) to register d with tag t clears d's pending flag at the next edge when d is pending and its stored tag equals t.
- R6: A commit whose tag differs from the stored tag, or whose register is not pending, leaves the entry unchanged.
- R7: When a decode write and a commit target the same register in the same cycle, the decode write wins. The entry ends pending with the new tag.
- R8: A lookup of a register that is being written in the same cycle returns the mapping held before that write.
- R9: Register 0 always reads pend=0, tag=0. Writes and commits to register 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_idx | input | IDX_W | Source A register index |
| rd1_idx | input | IDX_W | Source B register index |
| rd0_pend | output | 1 | Source A value pending in reorder buffer |
| rd0_tag | output | TAG_W | Source A producer tag (0 when not pending) |
| rd1_pend | output | 1 | Source B value pending in reorder buffer |
| rd1_tag | output | TAG_W | Source B producer tag (0 when not pending) |
| wr_en | input | 1 | Decode destination write strobe |
| wr_idx | input | IDX_W | Destination register index |
| wr_tag | input | TAG_W | Tag allocated to the decoding instruction |
| cm_en | input | 1 | Commit release strobe |
| cm_idx | input | IDX_W | Committing destination register |
| cm_tag | input | TAG_W | Committing instruction's tag |

## Verification
The bench targets a commit that arrives after a younger writer has remapped the register. A design that clears without comparing tags would make later readers use a stale register-file value. The bench also collides a decode write and a commit on the same register in the same cycle, where the wrong priority would drop a fresh mapping. It reads a register in the very cycle it is written; a forwarding design would make an instruction wait on its own tag. Writes and commits aimed at register 0 check that the hard-wired entry never turns pending.

// File: rtl/rnm_pkg.sv
// Package: shared constants and helpers for the rename map.
// Assumes register 0 is the hard-wired zero register.
package rnm_pkg;

    localparam int ZERO_REG = 0;

    // Returns 1 when the stored and offered tags are identical.
    function automatic logic tag_same(input logic [15:0] a, input logic [15:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/rnm_store.sv
// Module: rnm_store
// Holds one pending flag and one tag per architectural register.
// Applies the decode write and the tag-matched commit clear; decode wins a collision.
// Assumes TAG_W <= 16 and entry ZERO_REG is constant-zero.
module rnm_store #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 6,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic                             cm_en,
    input  logic [IDX_W-1:0]                 cm_idx,
    input  logic [TAG_W-1:0]                 cm_tag,
    output logic [NUM_REGS-1:0]              valid_q,
    output logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q
);
    import rnm_pkg::*;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_ent
        if (k == ZERO_REG) begin : g_zero
            // Hard-wired register: never pending.
            assign valid_q[k] = 1'b0;
            assign tag_q[k]   = '0;
        end else begin : g_live
            logic wr_hit;
            logic cm_hit;

            // Decode and commit address decode for this entry.
            assign wr_hit = wr_en && (wr_idx == IDX_W'(k));
            assign cm_hit = cm_en && (cm_idx == IDX_W'(k)) && valid_q[k] &&
                            tag_same(16'(tag_q[k]), 16'(cm_tag));

            // Entry update: reset, then decode write, then matched commit clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[k] <= 1'b0;
                    tag_q[k]   <= '0;
                end else if (wr_hit) begin
                    valid_q[k] <= 1'b1;
                    tag_q[k]   <= wr_tag;
                end else if (cm_hit) begin
                    valid_q[k] <= 1'b0;
                end
            end

            assert_write_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(k)) |=> (valid_q[k] && tag_q[k] == $past(wr_tag)));

            assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cm_en && cm_idx == IDX_W'(k) && valid_q[k] && tag_q[k] == cm_tag &&
                 !(wr_en && wr_idx == IDX_W'(k))) |=> !valid_q[k]);

            assert_mismatch_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cm_en && cm_idx == IDX_W'(k) && tag_q[k] != cm_tag &&
                 !(wr_en && wr_idx == IDX_W'(k))) |=> ($stable(valid_q[k]) && $stable(tag_q[k])));

            assert_decode_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(k) && cm_en && cm_idx == IDX_W'(k))
                |=> (valid_q[k] && tag_q[k] == $past(wr_tag)));
        end
    end

endmodule

// File: rtl/rnm_lookup.sv
// Module: rnm_lookup
// One source lookup port: selects an entry by index and reports pend and tag.
// Assumes the tag is reported as zero when the entry is not pending.
module rnm_lookup #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 6,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0]              valid_q,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q,
    output logic                             pend,
    output logic [TAG_W-1:0]                 tag
);
    import rnm_pkg::*;

    // Combinational entry select; old state only, no write bypass.
    always_comb begin
        pend = valid_q[idx];
        tag  = pend ? tag_q[idx] : '0;
    end

    assert_zero_reg_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_W'(ZERO_REG)) |-> (!pend && tag == '0));

endmodule

// File: rtl/rename_map.sv
// Module: rename_map
// Rename table: two source lookups, one decode write, one tag-matched commit clear.
// Assumes decode and commit each present at most one register per cycle.
module rename_map #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 6,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic             rd0_pend,
    output logic [TAG_W-1:0] rd0_tag,
    output logic             rd1_pend,
    output logic [TAG_W-1:0] rd1_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             cm_en,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic [TAG_W-1:0] cm_tag
);
    localparam int NPORTS = 2;

    logic [NUM_REGS-1:0]            valid_q;
    logic [NUM_REGS-1:0][TAG_W-1:0] tag_q;
    logic [NPORTS-1:0][IDX_W-1:0]   rd_idx;
    logic [NPORTS-1:0]              rd_pend;
    logic [NPORTS-1:0][TAG_W-1:0]   rd_tag;

    // Gather port indices and scatter results.
    assign rd_idx[0] = rd0_idx;
    assign rd_idx[1] = rd1_idx;
    assign rd0_pend  = rd_pend[0];
    assign rd0_tag   = rd_tag[0];
    assign rd1_pend  = rd_pend[1];
    assign rd1_tag   = rd_tag[1];

    rnm_store #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .cm_en   (cm_en),
        .cm_idx  (cm_idx),
        .cm_tag  (cm_tag),
        .valid_q (valid_q),
        .tag_q   (tag_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rnm_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_lookup (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (rd_idx[p]),
            .valid_q (valid_q),
            .tag_q   (tag_q),
            .pend    (rd_pend[p]),
            .tag     (rd_tag[p])
        );
    end

endmodule

// File: tb/rename_map_test.sv
`timescale 1ns/1ps
module rename_map_test;
    localparam int NR = 32;
    localparam int TW = 6;
    localparam int IW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0, cm_idx = '0;
    logic [TW-1:0] wr_tag = '0, cm_tag = '0;
    logic wr_en = 1'b0, cm_en = 1'b0;
    logic rd0_pend, rd1_pend;
    logic [TW-1:0] rd0_tag, rd1_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    bit          m_v[NR];
    int unsigned m_t[NR];

    always #10 clk = ~clk;

    rename_map #(.NUM_REGS(NR), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
        .rd0_pend(rd0_pend), .rd0_tag(rd0_tag),
        .rd1_pend(rd1_pend), .rd1_tag(rd1_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .cm_en(cm_en), .cm_idx(cm_idx), .cm_tag(cm_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_port(input string req, input int idx, input logic p, input logic [TW-1:0] t);
        int ep = (idx == 0) ? 0 : int'(m_v[idx]);
        int et = ep ? int'(m_t[idx]) : 0;
        string r = (idx == 0) ? "R9" : req;
        chk(p == ep[0], {r, " pend"}, int'(p), ep);
        chk(int'(t) == et, {r, " tag"}, int'(t), et);
    endtask

    // Apply one cycle: drive at negedge, compare before the edge, advance model.
    task automatic step(input string req, input int a0, input int a1,
                        input bit we, input int wi, input int wt,
                        input bit ce, input int ci, input int ct);
        rd0_idx = IW'(a0); rd1_idx = IW'(a1);
        wr_en = we; wr_idx = IW'(wi); wr_tag = TW'(wt);
        cm_en = ce; cm_idx = IW'(ci); cm_tag = TW'(ct);
        #1;
        cmp_port(req, a0, rd0_pend, rd0_tag);
        cmp_port(req, a1, rd1_pend, rd1_tag);
        @(posedge clk);
        if (ce && ci != 0 && m_v[ci] && m_t[ci] == ct && !(we && wi == ci)) m_v[ci] = 1'b0;
        if (we && wi != 0) begin m_v[wi] = 1'b1; m_t[wi] = wt; end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_v[i] = 1'b0; m_t[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: every entry idle after reset.
        for (int i = 0; i < NR; i += 2) step("R1", i, i + 1, 0, 0, 0, 0, 0, 0);

        // R8 then R4: same-cycle read sees old mapping, next cycle sees new.
        step("R8", 5, 5, 1, 5, 7, 0, 0, 0);
        step("R4", 5, 0, 0, 0, 0, 0, 0, 0);
        chk(rd0_pend == 1'b1 && rd0_tag == 6'd7, "R4 direct", int'(rd0_tag), 7);
        // R6: younger writer remaps; older commit must not release it.
        step("R4", 5, 0, 1, 5, 9, 0, 0, 0);
        step("R6", 5, 0, 0, 0, 0, 1, 5, 7);
        step("R6", 5, 0, 0, 0, 0, 0, 0, 0);
        chk(rd0_pend == 1'b1 && rd0_tag == 6'd9, "R6 direct", int'(rd0_tag), 9);
        // R5: matching commit releases.
        step("R5", 5, 0, 0, 0, 0, 1, 5, 9);
        step("R5", 5, 0, 0, 0, 0, 0, 0, 0);
        chk(rd0_pend == 1'b0, "R5 direct", int'(rd0_pend), 0);
        // R6: commit to non-pending entry has no effect.
        step("R6", 5, 0, 0, 0, 0, 1, 5, 0);
        step("R6", 5, 0, 0, 0, 0, 0, 0, 0);
        // R7: collision, decode wins.
        step("R7", 6, 0, 1, 6, 3, 0, 0, 0);
        step("R7", 6, 0, 1, 6, 4, 1, 6, 3);
        step("R7", 6, 0, 0, 0, 0, 0, 0, 0);
        chk(rd0_pend == 1'b1 && rd0_tag == 6'd4, "R7 direct", int'(rd0_tag), 4);
        // R9: register 0 ignores writes and commits.
        step("R9", 0, 0, 1, 0, 1, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        chk(rd0_pend == 1'b0 && rd0_tag == '0, "R9 direct", int'(rd0_pend), 0);
        // R3: both ports distinct registers.
        step("R3", 10, 11, 1, 11, 12, 0, 0, 0);
        step("R3", 6, 11, 0, 0, 0, 0, 0, 0);
        chk(rd0_tag == 6'd4 && rd1_tag == 6'd12, "R3 direct", int'(rd1_tag), 12);

        // R2: random traffic compared each cycle against the model.
        for (int n = 0; n < 3000; n++) begin
            int ci = $urandom_range(0, 7);
            int ct = ($urandom_range(0, 1) != 0) ? int'(m_t[ci]) : $urandom_range(0, 63);
            step("R2", $urandom_range(0, 7), $urandom_range(0, 7),
                 bit'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 63),
                 bit'($urandom_range(0, 1)), ci, ct);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule